// File: doc/BRIEF.md
# Three-State Run Controller with Mixed Output Styles

This block is a small synchronous controller driven by one serial input bit. It walks through three used states as long as the input stays high. It climbs from an idle state to a middle state and then to a top state, and it stays in the top state while the input remains high. Any low input sends it back to idle on the next clock edge. The state sits in two flip-flops. The next-state and output functions are reduced sums of products, and the one spare state code is treated as a don't-care when they are minimised.

Each used state drives exactly one state-only output. In the top state two further outputs follow the live input without waiting for a clock edge: one shows that the input has dropped, the other that it is still high. Both are low in every other state. A parameter selects the code loaded by the synchronous reset. Its default is idle. Setting it to the spare code makes the recovery path reachable.

Top module: `seq3_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state register loads `RESET_CODE` (default 2'b00, idle). With the default, only `mo_idle` is high after reset.
- R2: With `x_in` = 1 at a rising edge, idle (2'b00) moves to middle (2'b01), middle moves to top (2'b11), and top stays in top.
- R3: With `x_in` = 0 at a rising edge, every state moves to idle.
- R4: The state-only outputs are `mo_idle` for code 2'b00, `mo_mid` for 2'b01 and `mo_top` for 2'b11. Exactly one of them is high in each used state.
- R5: `me_drop` is high only in top with `x_in` = 0. `me_hold` is high only in top with `x_in` = 1.
- R6: In top, `me_drop` and `me_hold` follow a change of `x_in` within the same cycle, with no clock edge in between.
- R7: The state-only outputs change only after a rising clock edge. A change of `x_in` between edges leaves them unchanged.
- R8: In the spare code 2'b10 all five outputs are low. The next rising edge leaves it for middle if `x_in` = 1 and for idle if `x_in` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit |
| mo_idle | output | 1 | State-only output, high in idle |
| mo_mid | output | 1 | State-only output, high in middle |
| mo_top | output | 1 | State-only output, high in top |
| me_drop | output | 1 | Input-dependent output: top state with input low |
| me_hold | output | 1 | Input-dependent output: top state with input high |

## Verification
The bench builds two copies of the block. One uses the default reset code 2'b00 and walks the run-up, hold and fall-back sequences from idle. The other sets `RESET_CODE` to 2'b10, so that a reset places it in the spare code. Only this second copy can show that the spare code drives all outputs low and exits on the next edge, for either value of the input.

// File: rtl/seq3_ctl_pkg.sv
package seq3_ctl_pkg;
  localparam int unsigned ST_W = 2;
  typedef logic [ST_W-1:0] st_t;
  localparam st_t ST_IDLE  = 2'b00;
  localparam st_t ST_MID   = 2'b01;
  localparam st_t ST_TOP   = 2'b11;
  localparam st_t ST_SPARE = 2'b10;

  typedef struct packed {
    logic idle;
    logic mid;
    logic top;
    logic drop;
    logic hold;
  } outs_t;
endpackage

// File: rtl/seq3_ctl_next.sv
module seq3_ctl_next
  import seq3_ctl_pkg::*;
(
  input  st_t  cur,
  input  logic x,
  output st_t  nxt
);
  // Bit 1 (A): set only when the input is high and bit 0 (B) is already set.
  // Bit 0 (B): follows the input. The spare code was a don't-care in the reduction.
  always_comb begin
    nxt[1] = x & cur[0];
    nxt[0] = x;
  end
endmodule

// File: rtl/seq3_ctl_outs.sv
module seq3_ctl_outs
  import seq3_ctl_pkg::*;
(
  input  st_t   cur,
  input  logic  x,
  output outs_t o
);
  always_comb begin
    o.idle = ~cur[1] & ~cur[0];
    o.mid  = ~cur[1] &  cur[0];
    o.top  =  cur[1] &  cur[0];
    o.drop =  cur[1] &  cur[0] & ~x;
    o.hold =  cur[1] &  cur[0] &  x;
  end
endmodule

// File: rtl/seq3_ctl_state.sv
module seq3_ctl_state
  import seq3_ctl_pkg::*;
#(
  parameter st_t RESET_CODE = ST_IDLE
) (
  input  logic clk,
  input  logic rst,
  input  st_t  nxt,
  output st_t  cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= RESET_CODE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/seq3_ctl.sv
module seq3_ctl
  import seq3_ctl_pkg::*;
#(
  parameter logic [1:0] RESET_CODE = 2'b00
) (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic mo_idle,
  output logic mo_mid,
  output logic mo_top,
  output logic me_drop,
  output logic me_hold
);
  st_t   state_q;
  st_t   state_d;
  outs_t outs;

  seq3_ctl_next u_next (
    .cur (state_q),
    .x   (x_in),
    .nxt (state_d)
  );

  seq3_ctl_state #(.RESET_CODE(st_t'(RESET_CODE))) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  seq3_ctl_outs u_outs (
    .cur (state_q),
    .x   (x_in),
    .o   (outs)
  );

  assign mo_idle = outs.idle;
  assign mo_mid  = outs.mid;
  assign mo_top  = outs.top;
  assign me_drop = outs.drop;
  assign me_hold = outs.hold;
endmodule

// File: rtl/seq3_ctl_chk.sv
module seq3_ctl_chk #(
  parameter logic [1:0] RESET_CODE = 2'b00
) (
  input logic       clk,
  input logic       rst,
  input logic       x_in,
  input logic [1:0] state_q,
  input logic       mo_idle,
  input logic       mo_mid,
  input logic       mo_top,
  input logic       me_drop,
  input logic       me_hold
);
  logic [2:0] moore;
  assign moore = {mo_idle, mo_mid, mo_top};

  // R1
  a_r1_reset_load: assert property (@(posedge clk) rst |=> (state_q == RESET_CODE));
  // R2
  a_r2_climb_from_idle: assert property (@(posedge clk) disable iff (rst)
    (x_in && mo_idle) |=> mo_mid);
  a_r2_climb_to_top: assert property (@(posedge clk) disable iff (rst)
    (x_in && (mo_mid || mo_top)) |=> mo_top);
  // R3
  a_r3_fall_to_idle: assert property (@(posedge clk) disable iff (rst)
    !x_in |=> mo_idle);
  // R4
  a_r4_one_moore: assert property (@(posedge clk) disable iff (rst)
    $onehot0(moore));
  // R5
  a_r5_drop_only_top: assert property (@(posedge clk) disable iff (rst)
    me_drop |-> (mo_top && !x_in));
  a_r5_hold_only_top: assert property (@(posedge clk) disable iff (rst)
    me_hold |-> (mo_top && x_in));
  // R8
  a_r8_spare_exits: assert property (@(posedge clk) disable iff (rst)
    (moore == 3'b000) |=> (moore != 3'b000));
  a_r8_spare_quiet: assert property (@(posedge clk) disable iff (rst)
    (moore == 3'b000) |-> !(me_drop || me_hold));
endmodule

bind seq3_ctl seq3_ctl_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .x_in    (x_in),
  .state_q (state_q),
  .mo_idle (mo_idle),
  .mo_mid  (mo_mid),
  .mo_top  (mo_top),
  .me_drop (me_drop),
  .me_hold (me_hold)
);

// File: tb/seq3_ctl_tb.sv
module seq3_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // Each entry: {x, idle, mid, top, drop, hold}, checked before the edge that consumes x.
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1_10000, 6'b1_01000, 6'b1_00101, 6'b0_00110, 6'b0_10000, 6'b0_10000,
    6'b0_10000, 6'b1_10000, 6'b0_01000, 6'b1_10000, 6'b1_01000, 6'b0_00110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic xa = 1'b0;
  logic [4:0] o, oa;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq3_ctl u_dut (
    .clk(clk), .rst(rst), .x_in(x),
    .mo_idle(o[4]), .mo_mid(o[3]), .mo_top(o[2]), .me_drop(o[1]), .me_hold(o[0])
  );

  seq3_ctl #(.RESET_CODE(2'b10)) u_dut_alt (
    .clk(clk), .rst(rst), .x_in(xa),
    .mo_idle(oa[4]), .mo_mid(oa[3]), .mo_top(oa[2]), .me_drop(oa[1]), .me_hold(oa[0])
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    x = v;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset idle", o, 5'b10000);
    check("R8 spare outputs low", oa, 5'b00000);

    // Table walk: R2 climb, R3 fall, R4 one-hot, R5 conditional outputs
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5]);
      check($sformatf("R2/R3/R4/R5 vec %0d", i), o, VEC[i][4:0]);
    end

    // The last vector returned to idle; climb to top
    step(1'b1);
    step(1'b1);
    step(1'b1);
    check("R2 top holds", o, 5'b00101);
    x = 1'b0;
    #1;
    check("R6 drop follows x", o, 5'b00110);
    check("R7 moore stable", o[4:2], 3'b001);
    x = 1'b1;
    #1;
    check("R6 hold follows x", o, 5'b00101);

    // Reset from top
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    x = 1'b0;
    #1;
    check("R1 reset from top", o, 5'b10000);

    // Spare code exit with x=1 (alternate instance reset above)
    check("R8 spare after reset", oa, 5'b00000);
    xa = 1'b1;
    #1;
    check("R8 spare ignores x", oa, 5'b00000);
    @(negedge clk);
    #1;
    check("R8 spare exit x=1", oa, 5'b01000);

    // Spare code exit with x=0
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    xa = 1'b0;
    #1;
    check("R8 spare again", oa, 5'b00000);
    @(negedge clk);
    #1;
    check("R8 spare exit x=0", oa, 5'b10000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule